// File: doc/BRIEF.md
# Bus Read Command Selector

This block sits on the request side of a bus master, between the queue that holds pending transfers and the logic that drives the bus. Each request gives a direction, a start address up to 64 bits wide and a byte count. From these the block picks the bus command code to issue. For reads, the code depends on how many bytes are wanted: short reads, cache-line-sized reads and long multi-line reads each get their own code. Every write uses a single write code.

The block also decides whether the address needs two address phases. When any bit above bit 31 is set, a dual address cycle comes first. The address is then sent as a low 32-bit phase followed by a high 32-bit phase. A request with a byte count of zero is not turned into a command; the block raises an error pulse instead.

The result is held in an output register with a valid/ready handshake. It stays unchanged until the downstream side takes it. The block does not arbitrate, does not drive bus pins and does not move data.

Top module: `bus_cmd_select`

## Requirements
- R1: A read (req_write=0) with a byte count from 1 to 4 produces cmd_code 4'b0110.
- R2: A read with a byte count from 5 to 32 produces cmd_code 4'b1110.
- R3: A read with a byte count above 32 produces cmd_code 4'b1100.
- R4: A write (req_write=1) with a nonzero byte count produces cmd_code 4'b0111, whatever the count.
- R5: cmd_dac is 1 exactly when request address bits 63:32 are not all zero. cmd_addr_lo carries address bits 31:0. cmd_addr_hi carries bits 63:32, or zero when the address fits in 32 bits.
- R6: cmd_first_code is 4'b1101 (dual address cycle) when cmd_dac is 1, and equals cmd_code otherwise.
- R7: An accepted request with a byte count of 0 makes cmd_err high for exactly the one following cycle, and cmd_valid stays low for it.
- R8: While cmd_valid is 1 and cmd_ready is 0, all cmd_* outputs hold their values, req_ready is 0, and a waiting request is not taken.
- R9: While reset is asserted and after it is released, cmd_valid and cmd_err are 0. req_ready is 0 while reset is asserted.
- R10: An accepted request appears on the outputs one clock later. With cmd_ready held at 1, a new request can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block takes the request on this edge |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W (64) | Start address |
| req_count | input | CNT_W (13) | Byte count |
| cmd_valid | output | 1 | A command is held on the outputs |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_code | output | 4 | Main bus command code |
| cmd_first_code | output | 4 | Code for the first address phase |
| cmd_dac | output | 1 | A dual address cycle is needed |
| cmd_addr_lo | output | 32 | Address bits for the first phase |
| cmd_addr_hi | output | 32 | Address bits for the second phase |
| cmd_err | output | 1 | One-cycle pulse for a rejected zero-count request |

## Verification
The bench uses the default parameters: ADDR_W=64, CNT_W=13, a 4-byte word limit and a 32-byte line limit. With a 64-bit address, both the single-phase and the dual-phase paths can be reached. The 13-bit count covers every threshold edge (0, 1, 4, 5, 32, 33) as well as the largest count, 8191. Random requests mix small counts that cluster around the limits with counts spread over the full range, and mix addresses with and without upper bits set. Directed cases cover the zero-count rejection and a long downstream stall with a second request waiting.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam logic [3:0] CODE_MEM_RD      = 4'b0110;
  localparam logic [3:0] CODE_MEM_WR      = 4'b0111;
  localparam logic [3:0] CODE_MEM_RD_MULT = 4'b1100;
  localparam logic [3:0] CODE_MEM_RD_LINE = 4'b1110;
  localparam logic [3:0] CODE_DUAL_ADDR   = 4'b1101;

  typedef struct packed {
    logic [3:0]  code;
    logic [3:0]  first_code;
    logic        dac;
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
  } cmd_t;
endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bcs_cmd_decode.sv
module bcs_cmd_decode #(
  parameter int CNT_W      = 13,
  parameter int WORD_BYTES = 4,
  parameter int LINE_BYTES = 32
) (
  input  logic             is_write,
  input  logic [CNT_W-1:0] count,
  output logic [3:0]       code,
  output logic             zero_count
);
  import bcs_pkg::*;
  localparam logic [CNT_W-1:0] WORD_LIM = CNT_W'(WORD_BYTES);
  localparam logic [CNT_W-1:0] LINE_LIM = CNT_W'(LINE_BYTES);

  always_comb begin
    zero_count = (count == '0);
    if (is_write)               code = CODE_MEM_WR;
    else if (count <= WORD_LIM) code = CODE_MEM_RD;
    else if (count <= LINE_LIM) code = CODE_MEM_RD_LINE;
    else                        code = CODE_MEM_RD_MULT;
  end
endmodule

// File: rtl/bcs_addr_split.sv
module bcs_addr_split #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              dac,
  output logic [31:0]       lo,
  output logic [31:0]       hi
);
  generate
    if (ADDR_W > 32) begin : g_wide
      logic [63:0] wide;
      always_comb begin
        wide = 64'(addr);
        lo   = wide[31:0];
        hi   = wide[63:32];
        dac  = (wide[63:32] != 32'd0);
      end
    end else begin : g_narrow
      always_comb begin
        lo  = 32'(addr);
        hi  = 32'd0;
        dac = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/bcs_out_stage.sv
module bcs_out_stage (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_zero,
  input  bcs_pkg::cmd_t load_cmd,
  input  logic          cmd_ready,
  output logic          cmd_valid,
  output logic          cmd_err,
  output bcs_pkg::cmd_t cmd_out
);
  import bcs_pkg::*;
  logic valid_q, valid_d;
  logic err_q, err_d;
  cmd_t cmd_q, cmd_d;
  logic cmd_en;

  always_comb begin
    valid_d = valid_q;
    err_d   = load && load_zero;
    cmd_en  = load && !load_zero;
    cmd_d   = load_cmd;
    if (load)           valid_d = !load_zero;
    else if (cmd_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  assign cmd_valid = valid_q;
  assign cmd_err   = err_q;
  assign cmd_out   = cmd_q;

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !cmd_ready) |=> (valid_q && $stable(cmd_q)));
  assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !valid_q);
endmodule

// File: rtl/bus_cmd_select.sv
module bus_cmd_select #(
  parameter int ADDR_W     = 64,
  parameter int CNT_W      = 13,
  parameter int WORD_BYTES = 4,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [3:0]        cmd_code,
  output logic [3:0]        cmd_first_code,
  output logic              cmd_dac,
  output logic [31:0]       cmd_addr_lo,
  output logic [31:0]       cmd_addr_hi,
  output logic              cmd_err
);
  import bcs_pkg::*;
  localparam logic [CNT_W-1:0] WORD_LIM = CNT_W'(WORD_BYTES);
  localparam logic [CNT_W-1:0] LINE_LIM = CNT_W'(LINE_BYTES);

  logic        rst_sync_n;
  logic        fire;
  logic [3:0]  dec_code;
  logic        dec_zero;
  logic        split_dac;
  logic [31:0] split_lo, split_hi;
  cmd_t        new_cmd, held_cmd;

  bcs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  bcs_cmd_decode #(.CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES), .LINE_BYTES(LINE_BYTES)) u_dec (
    .is_write(req_write), .count(req_count), .code(dec_code), .zero_count(dec_zero));

  bcs_addr_split #(.ADDR_W(ADDR_W)) u_split (
    .addr(req_addr), .dac(split_dac), .lo(split_lo), .hi(split_hi));

  always_comb begin
    new_cmd.code       = dec_code;
    new_cmd.dac        = split_dac;
    new_cmd.first_code = split_dac ? CODE_DUAL_ADDR : dec_code;
    new_cmd.addr_lo    = split_lo;
    new_cmd.addr_hi    = split_hi;
  end

  assign req_ready = rst_sync_n && (!cmd_valid || cmd_ready);
  assign fire      = req_valid && req_ready;

  bcs_out_stage u_out (
    .clk(clk), .rst_n(rst_sync_n), .load(fire), .load_zero(dec_zero),
    .load_cmd(new_cmd), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
    .cmd_err(cmd_err), .cmd_out(held_cmd));

  assign cmd_code       = held_cmd.code;
  assign cmd_first_code = held_cmd.first_code;
  assign cmd_dac        = held_cmd.dac;
  assign cmd_addr_lo    = held_cmd.addr_lo;
  assign cmd_addr_hi    = held_cmd.addr_hi;

  assert_short_read_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && !req_write && req_count != '0 && req_count <= WORD_LIM) |=> (cmd_valid && cmd_code == 4'b0110));
  assert_line_read_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && !req_write && req_count > WORD_LIM && req_count <= LINE_LIM) |=> (cmd_valid && cmd_code == 4'b1110));
  assert_long_read_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && !req_write && req_count > LINE_LIM) |=> (cmd_valid && cmd_code == 4'b1100));
  assert_write_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && req_write && req_count != '0) |=> (cmd_valid && cmd_code == 4'b0111));
  assert_zero_reject_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && req_count == '0) |=> (cmd_err && !cmd_valid));
  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && !cmd_ready) |-> !req_ready);
  assert_reset_R9: assert property (@(posedge clk)
    !rst_sync_n |-> (!req_ready && !cmd_valid && !cmd_err));
endmodule

// File: tb/bus_cmd_select_test.sv
module bus_cmd_select_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [63:0] req_addr;
  logic [12:0] req_count;
  logic        cmd_valid, cmd_ready, cmd_dac, cmd_err;
  logic [3:0]  cmd_code, cmd_first_code;
  logic [31:0] cmd_addr_lo, cmd_addr_hi;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_cmd_select uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_count(req_count),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_first_code(cmd_first_code), .cmd_dac(cmd_dac), .cmd_addr_lo(cmd_addr_lo),
    .cmd_addr_hi(cmd_addr_hi), .cmd_err(cmd_err));

  function automatic logic [3:0] exp_code(input logic wr, input logic [12:0] n);
    if (wr)          return 4'b0111;
    else if (n <= 4)  return 4'b0110;
    else if (n <= 32) return 4'b1110;
    else              return 4'b1100;
  endfunction

  function automatic string req_tag(input logic wr, input logic [12:0] n);
    if (wr)          return "R4";
    else if (n <= 4)  return "R1";
    else if (n <= 32) return "R2";
    else              return "R3";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_cmd(input logic wr, input logic [63:0] a, input logic [12:0] n);
    logic dac;
    dac = (a[63:32] != 32'd0);
    check(req_tag(wr, n), {60'd0, cmd_code}, {60'd0, exp_code(wr, n)});
    check("R10 valid", {63'd0, cmd_valid}, 64'd1);
    check("R5 dac", {63'd0, cmd_dac}, {63'd0, dac});
    check("R5 lo", {32'd0, cmd_addr_lo}, {32'd0, a[31:0]});
    check("R5 hi", {32'd0, cmd_addr_hi}, {32'd0, a[63:32]});
    check("R6 first", {60'd0, cmd_first_code}, {60'd0, dac ? 4'b1101 : exp_code(wr, n)});
  endtask

  // drive at negedge, accepted at posedge, check at following negedge
  task automatic send(input logic wr, input logic [63:0] a, input logic [12:0] n);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_count = n;
    @(negedge clk);
    if (n == 13'd0) begin
      check("R7 err", {63'd0, cmd_err}, 64'd1);
      check("R7 no valid", {63'd0, cmd_valid}, 64'd0);
    end else begin
      check_cmd(wr, a, n);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    logic [12:0] n;
    logic wr;
    logic [3:0] held_code;
    logic [31:0] held_lo;
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_count = '0; cmd_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 ready in reset", {63'd0, req_ready}, 64'd0);
    check("R9 valid in reset", {63'd0, cmd_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 valid after", {63'd0, cmd_valid}, 64'd0);
    check("R9 err after", {63'd0, cmd_err}, 64'd0);
    check("R9 ready after", {63'd0, req_ready}, 64'd1);

    // directed threshold corners, back-to-back (R10)
    send(1'b0, 64'h0000_0000_1000_0000, 13'd1);
    send(1'b0, 64'h0000_0000_1000_0004, 13'd4);
    send(1'b0, 64'h0000_0001_2000_0000, 13'd5);
    send(1'b0, 64'h0000_0000_3000_0000, 13'd32);
    send(1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 13'd33);
    send(1'b0, 64'h8000_0000_0000_0000, 13'd8191);
    send(1'b1, 64'h0000_0000_0000_0010, 13'd1);
    send(1'b1, 64'h0000_00AB_0000_0000, 13'd8191);
    // zero count: error pulse for one cycle only (R7)
    send(1'b0, 64'h0000_0000_0000_0100, 13'd0);
    send(1'b1, 64'h0000_0001_0000_0100, 13'd0);
    req_valid = 1'b0;
    @(negedge clk);
    check("R7 err one cycle", {63'd0, cmd_err}, 64'd0);
    check("R7 still no valid", {63'd0, cmd_valid}, 64'd0);

    // stall with a waiting request (R8)
    cmd_ready = 1'b0;
    send(1'b0, 64'h0000_0002_0000_0040, 13'd64);
    held_code = cmd_code; held_lo = cmd_addr_lo;
    req_write = 1'b1; req_addr = 64'h0000_0000_0000_0800; req_count = 13'd16;
    repeat (3) @(negedge clk);
    check("R8 code held", {60'd0, cmd_code}, {60'd0, held_code});
    check("R8 lo held", {32'd0, cmd_addr_lo}, {32'd0, held_lo});
    check("R8 dac held", {63'd0, cmd_dac}, 64'd1);
    check("R8 valid held", {63'd0, cmd_valid}, 64'd1);
    check("R8 ready low", {63'd0, req_ready}, 64'd0);
    cmd_ready = 1'b1;
    @(negedge clk);
    check_cmd(1'b1, 64'h0000_0000_0000_0800, 13'd16);
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 drained", {63'd0, cmd_valid}, 64'd0);

    // constrained random
    for (int i = 0; i < 200; i++) begin
      wr = ($urandom % 4) == 0;
      n = ($urandom % 2) ? 13'($urandom % 40) : 13'($urandom);
      a = {$urandom, $urandom};
      if ($urandom % 2) a[63:32] = 32'd0;
      cmd_ready = 1'b1;
      send(wr, a, n);
    end
    req_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule